// File: doc/BRIEF.md
# Banked Memory Select and Swap Unit

This block sits on the CPU write path of a cartridge-style memory system and turns register writes in the upper half of the address space into bank numbers. It drives four 8 KB program slots, eight 1 KB pattern slots and one nametable mirroring flag. Software writes an index to a select register, then writes a bank number to a data register. The index decides which slot the number lands in.

Two bits of the select register control a swap mode, held as a small state machine. Bit 6 exchanges the contents of program slots 0 and 2. Bit 7 exchanges the lower and upper 4 KB halves of pattern space as the outputs present them. The states are:

- `MODE_DIRECT`: neither swap is active.
- `MODE_PRG_SWAP`: only the bit 6 program swap is active.
- `MODE_CHR_SWAP`: only the bit 7 pattern swap is active.
- `MODE_BOTH_SWAP`: both swaps are active.

Every select write is a transition to the state named by data bits 7:6, and this can be the same state. Reset enters `MODE_DIRECT`. Outer-bank masking, interrupts and the memories themselves belong to neighbouring blocks.

Top module: `bank_swap_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following values are loaded:
  - program slots 0..3 become 0, 1, count-2 and count-1, each truncated to 6 bits, where count is `prg_bank_count`;
  - pattern slot i becomes i;
  - mirroring becomes vertical (0);
  - the swap state becomes `MODE_DIRECT` and the stored index becomes 0.
  Program slot 3 never changes outside reset.
- R2: A write is decoded from `cpu_addr & 16'hE001`: 16'h8000 is the select register, 16'h8001 is the data register and 16'hA000 is the mirroring register. Any other address, or a cycle with `cpu_wr` low, leaves every output unchanged. Outputs change one clock edge after the write.
- R3: A data write with stored index 0 sets pattern slot 0 to the data with bit 0 cleared and slot 1 to the data with bit 0 set. Index 1 does the same for slots 2 and 3.
- R4: A data write with stored index 2, 3, 4 or 5 sets pattern slot 4, 5, 6 or 7 respectively to the full 8-bit data.
- R5: A data write with index 6 sets program slot 0 to data bits 5:0, or program slot 2 if the stored bit 6 is 1. Index 7 sets program slot 1. Indices 6 and 7 leave the pattern slots alone, and indices 0..5 leave the program slots alone.
- R6: A select write whose data bit 6 differs from the stored bit 6 exchanges program slots 0 and 2. A select write with equal bit 6 leaves them as they were. The stored index is data bits 2:0.
- R7: While the stored bit 7 is 1, output pattern slot i shows the bank held for slot i XOR 4. While it is 0, each slot shows its own bank.
- R8: A mirroring write sets `mirror_horiz_o` to data bit 0 (1 = horizontal, 0 = vertical).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one write per cycle it is high |
| prg_bank_count | input | CNT_W (7) | Number of 8 KB program banks, sampled during reset |
| prg_bank_o | output | 4*PRG_W (24) | Program slot banks, slot n at bits [n*PRG_W +: PRG_W] |
| chr_bank_o | output | 8*CHR_W (64) | Pattern 1 KB slot banks, slot n at bits [n*CHR_W +: CHR_W] |
| mirror_horiz_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench builds the block with its default widths: 6-bit program banks, 8-bit pattern banks and a 7-bit bank count. It resets once with a count of 16 and once with 64, which places the fixed top slots at 14/15 and at 62/63.

These widths allow a full sweep of all 256 data values for every index in every swap state. That sweep reaches every pair, single, program and swap path. It also covers aliased register addresses, non-decoded writes and full mirroring sweeps.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SELECT,
        CMD_DATA,
        CMD_MIRROR
    } bsu_cmd_e;

    // bit 1 = pattern halves swapped, bit 0 = program slots 0/2 swapped
    typedef enum logic [1:0] {
        MODE_DIRECT    = 2'b00,
        MODE_PRG_SWAP  = 2'b01,
        MODE_CHR_SWAP  = 2'b10,
        MODE_BOTH_SWAP = 2'b11
    } bsu_mode_e;

    localparam logic [15:0] DEC_MASK    = 16'hE001;
    localparam logic [15:0] ADDR_SELECT = 16'h8000;
    localparam logic [15:0] ADDR_DATA   = 16'h8001;
    localparam logic [15:0] ADDR_MIRROR = 16'hA000;

    localparam logic [2:0] IDX_PRG_A = 3'd6;
    localparam logic [2:0] IDX_PRG_B = 3'd7;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
    import bsu_pkg::*;
(
    input  logic [15:0] addr_i,
    input  logic        wr_i,
    output bsu_cmd_e    cmd_o
);

    logic [15:0] masked;

    assign masked = addr_i & DEC_MASK;

    always_comb begin
        cmd_o = CMD_NONE;
        if (wr_i) begin
            unique case (masked)
                ADDR_SELECT: cmd_o = CMD_SELECT;
                ADDR_DATA:   cmd_o = CMD_DATA;
                ADDR_MIRROR: cmd_o = CMD_MIRROR;
                default:     cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bsu_prg_bank.sv
module bsu_prg_bank #(
    parameter int PRG_W = 6,
    parameter int CNT_W = 7,
    parameter int SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       bank_count_i,
    input  logic                   swap_now_i,
    input  logic                   swapped_i,
    input  logic                   load_a_i,
    input  logic                   load_b_i,
    input  logic [PRG_W-1:0]       value_i,
    output logic [SLOTS*PRG_W-1:0] bank_o
);

    localparam int SWAP_LO = 0;
    localparam int SWAP_HI = 2;
    localparam int FIXED_B = 1;

    logic [PRG_W-1:0] slot_q [SLOTS];
    logic [CNT_W-1:0] last_m1;
    logic [CNT_W-1:0] last_m0;

    assign last_m1 = bank_count_i - CNT_W'(2);
    assign last_m0 = bank_count_i - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q[0] <= '0;
            slot_q[1] <= PRG_W'(1);
            slot_q[2] <= last_m1[PRG_W-1:0];
            slot_q[3] <= last_m0[PRG_W-1:0];
        end else if (swap_now_i) begin
            slot_q[SWAP_LO] <= slot_q[SWAP_HI];
            slot_q[SWAP_HI] <= slot_q[SWAP_LO];
        end else if (load_a_i) begin
            if (swapped_i) begin
                slot_q[SWAP_HI] <= value_i;
            end else begin
                slot_q[SWAP_LO] <= value_i;
            end
        end else if (load_b_i) begin
            slot_q[FIXED_B] <= value_i;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_out
        assign bank_o[g*PRG_W +: PRG_W] = slot_q[g];
    end

endmodule

// File: rtl/bsu_chr_bank.sv
module bsu_chr_bank #(
    parameter int CHR_W = 8,
    parameter int SLOTS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [2:0]             idx_i,
    input  logic [CHR_W-1:0]       value_i,
    input  logic                   halves_swapped_i,
    output logic [SLOTS*CHR_W-1:0] bank_o
);

    localparam int HALF = SLOTS / 2;

    logic [CHR_W-1:0] slot_q [SLOTS];
    logic [CHR_W-1:0] pair_even;
    logic [CHR_W-1:0] pair_odd;

    assign pair_even = {value_i[CHR_W-1:1], 1'b0};
    assign pair_odd  = {value_i[CHR_W-1:1], 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= CHR_W'(i);
            end
        end else if (load_i) begin
            unique case (idx_i)
                3'd0: begin
                    slot_q[0] <= pair_even;
                    slot_q[1] <= pair_odd;
                end
                3'd1: begin
                    slot_q[2] <= pair_even;
                    slot_q[3] <= pair_odd;
                end
                3'd2, 3'd3, 3'd4, 3'd5: slot_q[idx_i + 3'd2] <= value_i;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_view
        localparam int PARTNER = g ^ HALF;
        assign bank_o[g*CHR_W +: CHR_W] = halves_swapped_i ? slot_q[PARTNER] : slot_q[g];
    end

endmodule

// File: rtl/bank_swap_unit.sv
module bank_swap_unit
    import bsu_pkg::*;
#(
    parameter int PRG_W = 6,
    parameter int CHR_W = 8,
    parameter int CNT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_wr,
    input  logic [CNT_W-1:0]     prg_bank_count,
    output logic [4*PRG_W-1:0]   prg_bank_o,
    output logic [8*CHR_W-1:0]   chr_bank_o,
    output logic                 mirror_horiz_o
);

    localparam int PRG_SLOTS = 4;
    localparam int CHR_SLOTS = 8;

    bsu_cmd_e  cmd;
    bsu_mode_e mode_q, mode_d;
    logic [2:0] idx_q;
    logic       mirror_q;
    logic       prg_swapped;
    logic       chr_swapped;
    logic       prg_swap_now;

    bsu_decode u_decode (
        .addr_i (cpu_addr),
        .wr_i   (cpu_wr),
        .cmd_o  (cmd)
    );

    // swap-mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_DIRECT;
        end else begin
            mode_q <= mode_d;
        end
    end

    // swap-mode transitions: every select write names the next state
    always_comb begin
        mode_d = mode_q;
        if (cmd == CMD_SELECT) begin
            unique case (cpu_data[7:6])
                2'b00: mode_d = MODE_DIRECT;
                2'b01: mode_d = MODE_PRG_SWAP;
                2'b10: mode_d = MODE_CHR_SWAP;
                2'b11: mode_d = MODE_BOTH_SWAP;
            endcase
        end
    end

    // outputs of the swap state
    always_comb begin
        prg_swapped = 1'b0;
        chr_swapped = 1'b0;
        unique case (mode_q)
            MODE_DIRECT:    ;
            MODE_PRG_SWAP:  prg_swapped = 1'b1;
            MODE_CHR_SWAP:  chr_swapped = 1'b1;
            MODE_BOTH_SWAP: begin
                prg_swapped = 1'b1;
                chr_swapped = 1'b1;
            end
        endcase
    end

    assign prg_swap_now = (cmd == CMD_SELECT) && (cpu_data[6] != prg_swapped);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            mirror_q <= 1'b0;
        end else begin
            if (cmd == CMD_SELECT) begin
                idx_q <= cpu_data[2:0];
            end
            if (cmd == CMD_MIRROR) begin
                mirror_q <= cpu_data[0];
            end
        end
    end

    bsu_prg_bank #(
        .PRG_W (PRG_W),
        .CNT_W (CNT_W),
        .SLOTS (PRG_SLOTS)
    ) u_prg (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_count_i (prg_bank_count),
        .swap_now_i   (prg_swap_now),
        .swapped_i    (prg_swapped),
        .load_a_i     ((cmd == CMD_DATA) && (idx_q == IDX_PRG_A)),
        .load_b_i     ((cmd == CMD_DATA) && (idx_q == IDX_PRG_B)),
        .value_i      (cpu_data[PRG_W-1:0]),
        .bank_o       (prg_bank_o)
    );

    bsu_chr_bank #(
        .CHR_W (CHR_W),
        .SLOTS (CHR_SLOTS)
    ) u_chr (
        .clk              (clk),
        .rst_n            (rst_n),
        .load_i           (cmd == CMD_DATA),
        .idx_i            (idx_q),
        .value_i          (cpu_data[CHR_W-1:0]),
        .halves_swapped_i (chr_swapped),
        .bank_o           (chr_bank_o)
    );

    assign mirror_horiz_o = mirror_q;

endmodule

// File: rtl/bank_swap_unit_chk.sv
module bank_swap_unit_chk #(
    parameter int PRG_W = 6,
    parameter int CHR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [15:0]        cpu_addr,
    input logic [7:0]         cpu_data,
    input logic               cpu_wr,
    input logic [4*PRG_W-1:0] prg_bank_o,
    input logic [8*CHR_W-1:0] chr_bank_o,
    input logic               mirror_horiz_o,
    input logic [1:0]         mode_bits,
    input logic [2:0]         idx_bits
);

    logic        wr_sel, wr_dat, wr_mir;
    logic [15:0] am;

    assign am     = cpu_addr & 16'hE001;
    assign wr_sel = cpu_wr && (am == 16'h8000);
    assign wr_dat = cpu_wr && (am == 16'h8001);
    assign wr_mir = cpu_wr && (am == 16'hA000);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_horiz_o))); // R2

    AST_SLOT3_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(prg_bank_o[3*PRG_W +: PRG_W])); // R1

    AST_PRG_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (cpu_data[6] != mode_bits[0])) |=>
        (prg_bank_o[0 +: PRG_W] == $past(prg_bank_o[2*PRG_W +: PRG_W]) &&
         prg_bank_o[2*PRG_W +: PRG_W] == $past(prg_bank_o[0 +: PRG_W]))); // R6

    AST_PAIR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && idx_bits == 3'd0 && !mode_bits[1]) |=>
        (chr_bank_o[CHR_W +: CHR_W] == chr_bank_o[0 +: CHR_W] + CHR_W'(1) &&
         !chr_bank_o[0])); // R3

    AST_HALF_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (cpu_data[7] != mode_bits[1])) |=>
        (chr_bank_o[0 +: CHR_W] == $past(chr_bank_o[4*CHR_W +: CHR_W]) &&
         chr_bank_o[4*CHR_W +: CHR_W] == $past(chr_bank_o[0 +: CHR_W]))); // R7

    AST_MIRROR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mir |=> (mirror_horiz_o == $past(cpu_data[0]))); // R8

endmodule

bind bank_swap_unit bank_swap_unit_chk #(
    .PRG_W (PRG_W),
    .CHR_W (CHR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_addr       (cpu_addr),
    .cpu_data       (cpu_data),
    .cpu_wr         (cpu_wr),
    .prg_bank_o     (prg_bank_o),
    .chr_bank_o     (chr_bank_o),
    .mirror_horiz_o (mirror_horiz_o),
    .mode_bits      (mode_q),
    .idx_bits       (idx_q)
);

// File: tb/bank_swap_unit_tb_top.sv
`timescale 1ns/1ps
module bank_swap_unit_tb_top;

    localparam int PRG_W = 6;
    localparam int CHR_W = 8;
    localparam int CNT_W = 7;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [15:0]          cpu_addr = '0;
    logic [7:0]           cpu_data = '0;
    logic                 cpu_wr = 1'b0;
    logic [CNT_W-1:0]     prg_bank_count = CNT_W'(16);
    logic [4*PRG_W-1:0]   prg_bank_o;
    logic [8*CHR_W-1:0]   chr_bank_o;
    logic                 mirror_horiz_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int ep [4];
    int ec [8];
    int esel;
    int emir;

    always #4 clk = ~clk;

    bank_swap_unit #(.PRG_W(PRG_W), .CHR_W(CHR_W), .CNT_W(CNT_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_addr       (cpu_addr),
        .cpu_data       (cpu_data),
        .cpu_wr         (cpu_wr),
        .prg_bank_count (prg_bank_count),
        .prg_bank_o     (prg_bank_o),
        .chr_bank_o     (chr_bank_o),
        .mirror_horiz_o (mirror_horiz_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 4; i++)
            chk(req, $sformatf("prg slot %0d", i), int'(prg_bank_o[i*PRG_W +: PRG_W]), ep[i]);
        for (int i = 0; i < 8; i++) begin
            int src = ((esel & 8'h80) != 0) ? (i ^ 4) : i;
            chk(req, $sformatf("chr slot %0d", i), int'(chr_bank_o[i*CHR_W +: CHR_W]), ec[src]);
        end
        chk(req, "mirror", int'(mirror_horiz_o), emir);
    endtask

    task automatic model_reset(int cnt);
        ep[0] = 0; ep[1] = 1;
        ep[2] = (cnt - 2) & 63; ep[3] = (cnt - 1) & 63;
        for (int i = 0; i < 8; i++) ec[i] = i;
        esel = 0; emir = 0;
    endtask

    task automatic model_write(int a, int d);
        int m = a & 16'hE001;
        if (m == 16'h8000) begin
            if ((d & 8'h40) != (esel & 8'h40)) begin
                int t = ep[0]; ep[0] = ep[2]; ep[2] = t;
            end
            esel = d;
        end else if (m == 16'h8001) begin
            case (esel & 7)
                0: begin ec[0] = d & 8'hFE; ec[1] = (d & 8'hFE) + 1; end
                1: begin ec[2] = d & 8'hFE; ec[3] = (d & 8'hFE) + 1; end
                2, 3, 4, 5: ec[(esel & 7) + 2] = d;
                6: if ((esel & 8'h40) != 0) ep[2] = d & 63; else ep[0] = d & 63;
                default: ep[1] = d & 63;
            endcase
        end else if (m == 16'hA000) begin
            emir = d & 1;
        end
    endtask

    task automatic do_reset(int cnt);
        @(negedge clk);
        rst_n = 1'b0;
        prg_bank_count = CNT_W'(cnt);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset(cnt);
    endtask

    task automatic bus_write(int a, int d, bit en);
        @(negedge clk);
        cpu_addr = 16'(a);
        cpu_data = 8'(d);
        cpu_wr   = en;
        @(negedge clk);
        cpu_wr   = 1'b0;
        if (en) model_write(a, d);
    endtask

    initial begin
        do_reset(16);
        check_all("R1");

        // every index, every swap state, every data value
        for (int sel = 0; sel < 8; sel++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int d = 0; d < 256; d++) begin
                    bus_write(16'h8000, (mode << 6) | ((d & 7) << 3) | sel, 1'b1);
                    if (d % 32 == 0) check_all((mode & 1) != 0 ? "R6" : "R7");
                    bus_write(16'h8001, d, 1'b1);
                    if (sel < 2) check_all("R3");
                    else if (sel < 6) check_all("R4");
                    else check_all("R5");
                end
            end
        end

        // swap with unchanged bit 6 keeps slots; repeated toggles exchange
        bus_write(16'h8000, 8'h46, 1'b1);
        bus_write(16'h8001, 8'h15, 1'b1);
        bus_write(16'h8000, 8'h46, 1'b1);
        check_all("R6");
        bus_write(16'h8000, 8'h06, 1'b1);
        check_all("R6");

        // aliased register addresses decode like the base ones
        bus_write(16'h9FFE, 8'h83, 1'b1);
        bus_write(16'hFFFF & 16'h9FFF, 8'hA7, 1'b1);
        check_all("R2");

        for (int d = 0; d < 256; d++) begin
            bus_write((d & 1) ? 16'hBFFE : 16'hA000, d, 1'b1);
            check_all("R8");
        end

        // writes that must not touch any output
        begin
            int ign [8] = '{16'h6000, 16'hC000, 16'hC001, 16'hE000,
                            16'hE001, 16'hA001, 16'h0001, 16'h7FFF};
            foreach (ign[k]) begin
                bus_write(ign[k], 8'h5A + k, 1'b1);
                check_all("R2");
            end
            bus_write(16'h8001, 8'hEE, 1'b0);
            check_all("R2");
            bus_write(16'h8000, 8'hC0, 1'b0);
            check_all("R2");
        end

        do_reset(64);
        check_all("R1");
        bus_write(16'h8000, 8'h40, 1'b1);
        check_all("R1");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule